// File: doc/BRIEF.md
# Dual-ALU Operand Steering and Interlock Control

This control block serves a five-stage in-order pipeline that has two arithmetic units. The early unit sits in the first execute stage (EX1). The late unit shares the second execute stage with the data memory (EX2/MEM). For every register-register or register-immediate arithmetic instruction in decode, the block decides which unit executes it. An instruction whose source is produced one slot ahead, too late to be read in decode, is sent to the late unit. There it picks up the value through the bypass at the end of EX1, so it does not wait.

The block raises the one interlock that remains. A load or store in decode needs its base register by the end of decode, because the address is computed in EX1. It must wait one cycle when that base comes from a late producer. A late producer is a load, or an arithmetic instruction that was itself sent to the late unit. The late-unit flag for decode is registered into the EX1 stage on every non-stalled cycle. Because that registered flag feeds back into the next decision, a chain of dependent arithmetic after a load stays on the late unit. On a stall the EX1 copy becomes a bubble with the flag clear. The datapath inserts the matching bubble with write-enable off.

The EX1 opcode class, destination and write-enable come from the surrounding pipeline registers. Every pin is a plain level, sampled each cycle. There is no streaming handshake.

Top module: `dual_alu_steer`

## Requirements
- R1: An arithmetic instruction in decode (op class 1 = ALU register, 2 = ALU immediate) sets `alu2_id` when its `id_rs` equals `ex1_ws` and the EX1 instruction is a load (op class 3).
- R2: A match of `id_rt` with `ex1_ws` counts only when `id_rt_en` is 1. With `id_rt_en` at 0, an rt match alone leaves `alu2_id` at 0.
- R3: When the EX1 instruction is arithmetic and `alu2_ex1` is 1, a dependent arithmetic instruction in decode sets `alu2_id`. When the EX1 instruction is arithmetic with `alu2_ex1` at 0, `alu2_id` stays 0.
- R4: An EX1 destination of register 0, or `ex1_we` at 0, never produces a match: `alu2_id` and `stall` both stay 0.
- R5: Op classes other than 1 and 2 never set `alu2_id`. These are 0 = none, 3 = load, 4 = store and 5 = branch.
- R6: `stall` is 1 when a load (3) or store (4) in decode has `id_rs` equal to a valid EX1 destination, and the EX1 instruction is a load or has `alu2_ex1` at 1.
- R7: A store whose data register (`id_rt`) alone matches a load in EX1 does not stall. A load or store whose base comes from an EX1 instruction using the early unit does not stall. An arithmetic instruction never stalls.
- R8: `alu2_ex1` is 0 after reset. On a cycle without stall it takes the value `alu2_id` had before the edge. On a stall cycle it becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_op | input | 3 | Op class of the decode instruction |
| id_rs | input | 5 | First source / base register in decode |
| id_rt | input | 5 | Second source / store data register in decode |
| id_rt_en | input | 1 | Decode instruction reads `id_rt` |
| ex1_op | input | 3 | Op class of the EX1 instruction |
| ex1_ws | input | 5 | Destination register of the EX1 instruction |
| ex1_we | input | 1 | EX1 instruction writes a register |
| alu2_id | output | 1 | Decode instruction goes to the late unit |
| stall | output | 1 | Hold decode, insert bubble into EX1 |
| alu2_ex1 | output | 1 | Registered late-unit flag of the EX1 instruction |

## Verification
A wrong flag in the EX1 register shows at the ports one cycle later. It appears on `alu2_ex1` directly. It also appears on the next decision that depends on the EX1 instruction: a dependent arithmetic op on the wrong unit, or a load or store that stalls when it should not, or fails to stall when it should. The vector table runs dependence chains through consecutive cycles, so a corrupted feedback bit changes the very next expected output. A broken comparator or a missing qualifier (zero destination, write-enable, rt read-enable, op class) shows in the combinational outputs in the same cycle as the stimulus.

// File: rtl/dual_alu_pkg.sv
package dual_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_NONE  = 3'd0,
    OPC_ALU   = 3'd1,
    OPC_ALUI  = 3'd2,
    OPC_LOAD  = 3'd3,
    OPC_STORE = 3'd4,
    OPC_BR    = 3'd5
  } opc_e;

  function automatic logic is_arith(input opc_e op);
    return (op == OPC_ALU) || (op == OPC_ALUI);
  endfunction

  function automatic logic is_mem(input opc_e op);
    return (op == OPC_LOAD) || (op == OPC_STORE);
  endfunction
endpackage

// File: rtl/reg_dep_match.sv
// Compares one source field against the EX1 destination; a register
// zero destination or a non-writing producer never matches.
module reg_dep_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic [REG_AW-1:0] dst,
  input  logic              dst_we,
  output logic              hit
);
  logic dst_valid;
  always_comb begin
    dst_valid = dst_we && (dst != '0);
    hit       = src_used && dst_valid && (src == dst);
  end
endmodule

// File: rtl/steer_unit.sv
module steer_unit #(
  parameter int REG_AW = 5
) (
  input  dual_alu_pkg::opc_e id_op,
  input  logic [REG_AW-1:0]  id_rs,
  input  logic [REG_AW-1:0]  id_rt,
  input  logic               id_rt_en,
  input  logic [REG_AW-1:0]  ex1_ws,
  input  logic               ex1_we,
  input  logic               ex1_late,
  output logic               to_alu2
);
  import dual_alu_pkg::*;
  localparam int NSRC = 2;

  logic [NSRC-1:0]        src_hit;
  logic [NSRC-1:0][REG_AW-1:0] src_reg;
  logic [NSRC-1:0]        src_use;

  assign src_reg[0] = id_rs;
  assign src_use[0] = 1'b1;
  assign src_reg[1] = id_rt;
  assign src_use[1] = id_rt_en;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    reg_dep_match #(.REG_AW(REG_AW)) u_match (
      .src     (src_reg[g]),
      .src_used(src_use[g]),
      .dst     (ex1_ws),
      .dst_we  (ex1_we),
      .hit     (src_hit[g])
    );
  end

  always_comb to_alu2 = is_arith(id_op) && ex1_late && (|src_hit);

  // R5: only arithmetic classes are ever steered
  always_comb begin
    if (to_alu2) assert (is_arith(id_op)) else $error("p_steer_arith_only_r5");
  end
endmodule

// File: rtl/interlock_unit.sv
module interlock_unit #(
  parameter int REG_AW = 5
) (
  input  dual_alu_pkg::opc_e id_op,
  input  logic [REG_AW-1:0]  id_rs,
  input  logic [REG_AW-1:0]  ex1_ws,
  input  logic               ex1_we,
  input  logic               ex1_late,
  output logic               hold
);
  import dual_alu_pkg::*;
  logic base_hit;

  // Only the base register must be ready by end of decode; store data
  // is needed one stage later and is bypassed in time (R7).
  reg_dep_match #(.REG_AW(REG_AW)) u_base (
    .src     (id_rs),
    .src_used(is_mem(id_op)),
    .dst     (ex1_ws),
    .dst_we  (ex1_we),
    .hit     (base_hit)
  );

  always_comb hold = base_hit && ex1_late;

  // R7: arithmetic instructions never interlock
  always_comb begin
    if (hold) assert (!is_arith(id_op)) else $error("p_arith_no_stall_r7");
  end
endmodule

// File: rtl/alu2_stage_reg.sv
module alu2_stage_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic flag_in,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (hold) flag_q <= 1'b0;
    else           flag_q <= flag_in;
  end

  p_pipe_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold)) |-> (flag_q == $past(flag_in)))
    else $error("p_pipe_follow_r8");

  p_bubble_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold)) |-> !flag_q)
    else $error("p_bubble_clear_r8");
endmodule

// File: rtl/dual_alu_steer.sv
module dual_alu_steer #(
  parameter int REG_AW = 5,
  parameter int OP_W   = dual_alu_pkg::OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   id_op,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rt_en,
  input  logic [OP_W-1:0]   ex1_op,
  input  logic [REG_AW-1:0] ex1_ws,
  input  logic              ex1_we,
  output logic              alu2_id,
  output logic              stall,
  output logic              alu2_ex1
);
  import dual_alu_pkg::*;

  opc_e id_opc, ex1_opc;
  logic ex1_late;

  always_comb begin
    id_opc   = opc_e'(id_op);
    ex1_opc  = opc_e'(ex1_op);
    // producer whose value appears only at end of EX2/MEM
    ex1_late = (ex1_opc == OPC_LOAD) || alu2_ex1;
  end

  steer_unit #(.REG_AW(REG_AW)) u_steer (
    .id_op   (id_opc),
    .id_rs   (id_rs),
    .id_rt   (id_rt),
    .id_rt_en(id_rt_en),
    .ex1_ws  (ex1_ws),
    .ex1_we  (ex1_we),
    .ex1_late(ex1_late),
    .to_alu2 (alu2_id)
  );

  interlock_unit #(.REG_AW(REG_AW)) u_lock (
    .id_op   (id_opc),
    .id_rs   (id_rs),
    .ex1_ws  (ex1_ws),
    .ex1_we  (ex1_we),
    .ex1_late(ex1_late),
    .hold    (stall)
  );

  alu2_stage_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (stall),
    .flag_in(alu2_id),
    .flag_q (alu2_ex1)
  );

  p_no_dual_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && alu2_id)) else $error("p_no_dual_action_r7");

  p_dead_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex1_we || ex1_ws == '0) |-> (!alu2_id && !stall))
    else $error("p_dead_dest_r4");

  p_steer_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alu2_id |-> (ex1_opc == OPC_LOAD || alu2_ex1))
    else $error("p_steer_cause_r3");
endmodule

// File: tb/tb_dual_alu_steer.sv
module tb_dual_alu_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] id_op = '0, ex1_op = '0;
  logic [4:0] id_rs = '0, id_rt = '0, ex1_ws = '0;
  logic id_rt_en = 1'b0, ex1_we = 1'b0;
  logic alu2_id, stall, alu2_ex1;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_alu_steer dut (
    .clk(clk), .rst_n(rst_n), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt),
    .id_rt_en(id_rt_en), .ex1_op(ex1_op), .ex1_ws(ex1_ws), .ex1_we(ex1_we),
    .alu2_id(alu2_id), .stall(stall), .alu2_ex1(alu2_ex1)
  );

  // {id_op, rs, rt, rt_en, ex1_op, ws, we, exp_alu2, exp_stall}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {3'd1, 5'd1, 5'd2, 1'b1, 3'd3, 5'd1, 1'b1, 1'b1, 1'b0}, // R1 rs after load
    {3'd1, 5'd5, 5'd4, 1'b1, 3'd1, 5'd5, 1'b1, 1'b1, 1'b0}, // R3 chain rs
    {3'd1, 5'd9, 5'd6, 1'b1, 3'd1, 5'd6, 1'b1, 1'b1, 1'b0}, // R2 chain via rt
    {3'd2, 5'd7, 5'd6, 1'b0, 3'd1, 5'd6, 1'b1, 1'b0, 1'b0}, // R2 rt unused
    {3'd1, 5'd6, 5'd0, 1'b1, 3'd1, 5'd6, 1'b1, 1'b0, 1'b0}, // R3 early producer
    {3'd3, 5'd4, 5'd0, 1'b0, 3'd1, 5'd4, 1'b1, 1'b0, 1'b0}, // R7 base from ALU1
    {3'd1, 5'd0, 5'd0, 1'b1, 3'd3, 5'd0, 1'b1, 1'b0, 1'b0}, // R4 reg zero
    {3'd1, 5'd8, 5'd0, 1'b1, 3'd3, 5'd8, 1'b0, 1'b0, 1'b0}, // R4 we off
    {3'd3, 5'd8, 5'd0, 1'b0, 3'd3, 5'd8, 1'b1, 1'b0, 1'b1}, // R6 load-load base
    {3'd4, 5'd3, 5'd8, 1'b1, 3'd3, 5'd8, 1'b1, 1'b0, 1'b0}, // R7 store data
    {3'd1, 5'd8, 5'd0, 1'b1, 3'd3, 5'd8, 1'b1, 1'b1, 1'b0}, // R1 again
    {3'd4, 5'd8, 5'd2, 1'b1, 3'd1, 5'd8, 1'b1, 1'b0, 1'b1}, // R6 store base ALU2
    {3'd4, 5'd8, 5'd2, 1'b1, 3'd0, 5'd0, 1'b0, 1'b0, 1'b0}, // R8 bubble ahead
    {3'd5, 5'd1, 5'd1, 1'b1, 3'd3, 5'd1, 1'b1, 1'b0, 1'b0}, // R5 branch
    {3'd3, 5'd2, 5'd0, 1'b0, 3'd1, 5'd2, 1'b1, 1'b0, 1'b0}  // R7 load from ALU1
  };
  string tag [NV];

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [24:0] v);
    {id_op, id_rs, id_rt, id_rt_en, ex1_op, ex1_ws, ex1_we} = v[24:2];
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = '{"R1","R3","R2","R2","R3","R7","R4","R4","R6","R7","R1","R6","R8","R5","R7"};
    repeat (3) @(posedge clk);
    #2 chk("R8 reset value", alu2_ex1, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    #2 chk("R8 idle after reset", alu2_ex1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #2;
      chk({tag[i], " alu2_id"}, alu2_id, VEC[i][1]);
      chk({tag[i], " stall"},   stall,   VEC[i][0]);
      @(posedge clk);
      #2 chk("R8 registered flag", alu2_ex1, VEC[i][0] ? 1'b0 : VEC[i][1]);
    end

    // R8: flag set then reset clears it
    @(negedge clk);
    drive(VEC[0]);
    @(posedge clk);
    #2 chk("R8 flag captured", alu2_ex1, 1'b1);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #2 chk("R8 reset clears flag", alu2_ex1, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R5: store after load with base match stalls, but never steers
    drive({3'd4, 5'd1, 5'd1, 1'b1, 3'd3, 5'd1, 1'b1, 2'b00});
    #2 chk("R5 store not steered", alu2_id, 1'b0);
    chk("R6 store base after load", stall, 1'b1);
    @(posedge clk);
    #2 chk("R8 stall bubble", alu2_ex1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule